// File: doc/BRIEF.md
# Instruction Fetch Sequencer

This block is the fetch part of a small processor control unit. It steps through four timing slices. In the first slice the program counter is copied into the address register. In the second slice a read is issued and the returned word is captured into the data buffer. In the third slice the buffer is moved into the instruction register. The fourth slice is a decode/execute slot. The counter advances by one at some point in each round, and then the round repeats. All memory traffic goes through the address register and the data buffer: the address bus is the address register, and read data lands only in the buffer.

Transfers between the internal registers use one shared internal bus. Either the program counter or the buffer drives it, one source per slice. A mode input picks one of two orderings. In the normal ordering the counter increments in the third slice, together with the instruction-register load. In the alternate ordering the increment moves into the second slice, beside the memory read. After the fourth slice both orderings leave every register in the same state. The mode is taken only at the end of the first slice, so a change during a round takes effect at the next round.

Top module: `fetch_seq_top`

## Requirements
- R1: While reset is low, and after any reset, the program counter reads RESET_PC. The address bus, instruction output, read strobe and execute strobe all read 0, and the sequencer is in slice T1. Counting from the first rising edge after reset is released, rising edge n ends slice T1, T2, T3 or T4 according to n mod 4 = 1, 2, 3 or 0.
- R2: The address bus changes only at the end of T1, where it takes the program counter value. From T2 up to the end of the next T1 it shows the address of the current fetch.
- R3: The read strobe is 1 during T2 and 0 in every other slice.
- R4: The read data present during T2 is captured into the buffer at the end of T2. It reaches the instruction output at the end of T3, so it is visible in T4.
- R5: With the mode sampled as 0, the program counter increments at the end of T3. It therefore still shows the fetch address in T3 and shows the new value in T4.
- R6: With the mode sampled as 1, the program counter increments at the end of T2. It therefore already shows the new value in T3.
- R7: The increment is exactly +1, modulo 2^PC_W.
- R8: The execute strobe is 1 for exactly the single cycle of T4. The instruction output and the program counter do not change across the end of T4.
- R9: The mode input is taken only at the end of T1. Changing it during T2, T3 or T4 does not change where the current round increments.
- R10: The program counter never changes at the end of T1, which is the slice in which the address register is loaded from it.
- R11: The slices repeat T1, T2, T3, T4 without gaps, so execute strobes are exactly four cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alt_order | input | 1 | Ordering mode: 0 increments in T3, 1 increments in T2 |
| mem_rdata | input | DATA_W | Read data returned by memory, combinational on mem_addr |
| mem_addr | output | PC_W | Address bus, driven by the address register |
| mem_rd | output | 1 | Memory read strobe |
| instr | output | DATA_W | Instruction register contents |
| exec_stb | output | 1 | Decode/execute slot strobe |
| pc_q | output | PC_W | Program counter contents |

## Verification
The bench uses a 4-bit counter that starts near the top of its range. It runs more than two full wraps of the address space and compares the program counter against a modulo value in every slice. An incrementer that carries out or sticks at the top would show up as a wrong address after the wrap.

Each round picks one of the two orderings. Some rounds also flip the mode input right after T1, so a design that reads the mode directly instead of its T1 sample would increment in the wrong slice. Those rounds are exactly where that design misplaces the increment.

The read data differs for every address, so a buffer or instruction-register load that is one slice early or late gives a wrong instruction in T4. The same check catches a read from a stale address.

A reset in the middle of a round must restart the count at the reset value and clear the instruction output. A design that kept its slice position or counter across that reset would then fetch from the wrong address.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;

   typedef enum logic [1:0] {
      SL_T1 = 2'd0,
      SL_T2 = 2'd1,
      SL_T3 = 2'd2,
      SL_T4 = 2'd3
   } slice_e;

   // One-slice transfer controls
   typedef struct packed {
      logic bus_from_pc;   // internal bus source: 1 = program counter, 0 = buffer
      logic ld_mar;
      logic ld_mbr;
      logic ld_ir;
      logic inc_pc;
      logic rd;
      logic exec;
   } xfer_ctl_t;

   localparam xfer_ctl_t XFER_IDLE = '0;

   function automatic slice_e next_slice(input slice_e s);
      unique case (s)
         SL_T1:   return SL_T2;
         SL_T2:   return SL_T3;
         SL_T3:   return SL_T4;
         default: return SL_T1;
      endcase
   endfunction

endpackage

// File: rtl/fetch_slice_ctrl.sv
module fetch_slice_ctrl
   import fetch_seq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      alt_order,
   output slice_e    slice_q,
   output xfer_ctl_t ctl
);

   logic mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slice_q <= SL_T1;
      end else begin
         slice_q <= next_slice(slice_q);
      end
   end

   // ordering mode captured once per round, at the close of T1
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
      end else if (slice_q == SL_T1) begin
         mode_q <= alt_order;
      end
   end

   always_comb begin
      ctl = XFER_IDLE;
      unique case (slice_q)
         SL_T1: begin
            ctl.bus_from_pc = 1'b1;
            ctl.ld_mar      = 1'b1;
         end
         SL_T2: begin
            ctl.rd     = 1'b1;
            ctl.ld_mbr = 1'b1;
            ctl.inc_pc = mode_q;
         end
         SL_T3: begin
            ctl.ld_ir  = 1'b1;
            ctl.inc_pc = ~mode_q;
         end
         default: begin
            ctl.exec = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit #(
   parameter int unsigned          PC_W     = 16,
   parameter logic [PC_W-1:0]      RESET_PC = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            inc,
   output logic [PC_W-1:0] pc_q
);

   localparam logic [PC_W-1:0] STEP = PC_W'(1);

   logic [PC_W-1:0] pc_next;

   // width-limited add: wraps at 2**PC_W
   assign pc_next = pc_q + STEP;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= RESET_PC;
      end else if (inc) begin
         pc_q <= pc_next;
      end
   end

endmodule

// File: rtl/fetch_xfer_regs.sv
module fetch_xfer_regs
   import fetch_seq_pkg::*;
#(
   parameter int unsigned PC_W   = 16,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  xfer_ctl_t         ctl,
   input  logic [PC_W-1:0]   pc,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [PC_W-1:0]   mar_q,
   output logic [DATA_W-1:0] ir_q
);

   localparam int unsigned BUS_W = DATA_W;
   localparam int unsigned PAD_W = BUS_W - PC_W;

   logic [DATA_W-1:0] mbr_q;
   logic [BUS_W-1:0]  pc_on_bus;
   logic [BUS_W-1:0]  ibus;

   // counter placed on the shared bus, zero-extended when narrower
   generate
      if (PAD_W == 0) begin : g_pc_full
         assign pc_on_bus = pc;
      end else begin : g_pc_pad
         assign pc_on_bus = {{PAD_W{1'b0}}, pc};
      end
   endgenerate

   assign ibus = ctl.bus_from_pc ? pc_on_bus : mbr_q;

   // address register: sole driver of the address bus
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mar_q <= '0;
      end else if (ctl.ld_mar) begin
         mar_q <= ibus[PC_W-1:0];
      end
   end

   // buffer register: sole receiver of memory data
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mbr_q <= '0;
      end else if (ctl.ld_mbr) begin
         mbr_q <= mem_rdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ir_q <= '0;
      end else if (ctl.ld_ir) begin
         ir_q <= ibus;
      end
   end

endmodule

// File: rtl/fetch_seq_top.sv
module fetch_seq_top
   import fetch_seq_pkg::*;
#(
   parameter int unsigned     PC_W     = 16,
   parameter int unsigned     DATA_W   = 16,
   parameter logic [PC_W-1:0] RESET_PC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alt_order,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [PC_W-1:0]   mem_addr,
   output logic              mem_rd,
   output logic [DATA_W-1:0] instr,
   output logic              exec_stb,
   output logic [PC_W-1:0]   pc_q
);

   generate
      if (PC_W < 2 || PC_W > 32) begin : g_bad_pc_w
         $error("fetch_seq_top: PC_W must lie in 2..32");
      end
      if (DATA_W < PC_W) begin : g_bad_data_w
         $error("fetch_seq_top: DATA_W must be at least PC_W");
      end
   endgenerate

   slice_e    slice_q;
   xfer_ctl_t ctl;

   fetch_slice_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .alt_order (alt_order),
      .slice_q   (slice_q),
      .ctl       (ctl)
   );

   fetch_pc_unit #(
      .PC_W     (PC_W),
      .RESET_PC (RESET_PC)
   ) u_pc (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ctl.inc_pc),
      .pc_q  (pc_q)
   );

   fetch_xfer_regs #(
      .PC_W   (PC_W),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl       (ctl),
      .pc        (pc_q),
      .mem_rdata (mem_rdata),
      .mar_q     (mem_addr),
      .ir_q      (instr)
   );

   assign mem_rd   = ctl.rd;
   assign exec_stb = ctl.exec;

endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk #(
   parameter int unsigned PC_W   = 16,
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_t1,
   input logic [PC_W-1:0]   mem_addr,
   input logic              mem_rd,
   input logic [DATA_W-1:0] mem_rdata,
   input logic [DATA_W-1:0] instr,
   input logic              exec_stb,
   input logic [PC_W-1:0]   pc_q
);

   // R2
   addr_matches_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> mem_addr == $past(pc_q));

   // R2
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_t1 |=> $stable(mem_addr));

   // R3
   rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd);

   // R3
   rd_excl_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && exec_stb));

   // R4
   ir_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> ##1 instr == $past(mem_rdata, 2));

   // R7
   pc_plus_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exec_stb |-> pc_q == PC_W'(mem_addr + PC_W'(1)));

   // R8
   exec_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exec_stb |=> !exec_stb);

   // R8
   exec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exec_stb |=> $stable(instr) && $stable(pc_q));

   // R10
   no_inc_on_mar_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_t1 |=> $stable(pc_q));

   // R11
   exec_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exec_stb |-> ##4 exec_stb);

endmodule

bind fetch_seq_top fetch_seq_chk #(
   .PC_W   (PC_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_t1     (slice_q == fetch_seq_pkg::SL_T1),
   .mem_addr  (mem_addr),
   .mem_rd    (mem_rd),
   .mem_rdata (mem_rdata),
   .instr     (instr),
   .exec_stb  (exec_stb),
   .pc_q      (pc_q)
);

// File: tb/fetch_seq_top_tb_top.sv
module fetch_seq_top_tb_top;

   localparam int unsigned PC_W    = 4;
   localparam int unsigned DATA_W  = 8;
   localparam logic [3:0]  RST_PC  = 4'hC;
   localparam time         CLK_PER = 10ns;
   localparam int          MEM_N   = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              alt_order = 1'b0;
   logic [DATA_W-1:0] mem_rdata;
   logic [PC_W-1:0]   mem_addr;
   logic              mem_rd;
   logic [DATA_W-1:0] instr;
   logic              exec_stb;
   logic [PC_W-1:0]   pc_q;

   logic [DATA_W-1:0] mem [MEM_N];

   int          checks = 0;
   int          errors = 0;
   bit          done   = 1'b0;
   logic [3:0]  exp_pc;
   logic [7:0]  exp_ir;

   always #(CLK_PER/2) clk = ~clk;

   function automatic logic [7:0] word_at(input logic [3:0] a);
      return 8'((32'(a) * 29 + 7) & 32'hFF);
   endfunction

   initial begin
      for (int i = 0; i < MEM_N; i++) mem[i] = word_at(4'(i));
   end

   assign mem_rdata = mem[mem_addr];

   fetch_seq_top #(
      .PC_W     (PC_W),
      .DATA_W   (DATA_W),
      .RESET_PC (RST_PC)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .alt_order (alt_order),
      .mem_rdata (mem_rdata),
      .mem_addr  (mem_addr),
      .mem_rd    (mem_rd),
      .instr     (instr),
      .exec_stb  (exec_stb),
      .pc_q      (pc_q)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic reset_state_checks();
      chk("R1", "pc", 32'(pc_q), 32'(RST_PC));
      chk("R1", "addr", 32'(mem_addr), 0);
      chk("R1", "instr", 32'(instr), 0);
      chk("R1", "rd", 32'(mem_rd), 0);
      chk("R1", "exec", 32'(exec_stb), 0);
   endtask

   // one full round, entered and left at a T1 negedge
   task automatic run_fetch(input bit mode, input bit disturb);
      logic [3:0] nxt;
      nxt = exp_pc + 4'd1;           // R7 modulo 16
      alt_order = mode;
      chk("R3", "rd in T1", 32'(mem_rd), 0);
      step();                         // T2
      chk("R2", "addr in T2", 32'(mem_addr), 32'(exp_pc));
      chk("R3", "rd in T2", 32'(mem_rd), 1);
      chk("R10", "pc after T1", 32'(pc_q), 32'(exp_pc));
      if (disturb) alt_order = ~mode; // R9 late change ignored
      step();                         // T3
      chk("R3", "rd in T3", 32'(mem_rd), 0);
      if (mode) chk("R6", "pc in T3", 32'(pc_q), 32'(nxt));
      else      chk("R5", "pc in T3", 32'(pc_q), 32'(exp_pc));
      if (disturb) chk("R9", "pc in T3 after mode flip", 32'(pc_q),
                       mode ? 32'(nxt) : 32'(exp_pc));
      step();                         // T4
      chk("R8", "exec in T4", 32'(exec_stb), 1);
      chk("R4", "instr in T4", 32'(instr), 32'(word_at(exp_pc)));
      chk("R7", "pc in T4", 32'(pc_q), 32'(nxt));
      exp_ir = word_at(exp_pc);
      step();                         // next T1
      chk("R8", "exec after T4", 32'(exec_stb), 0);
      chk("R8", "instr held", 32'(instr), 32'(exp_ir));
      chk("R11", "addr held into T1", 32'(mem_addr), 32'(exp_pc));
      exp_pc = nxt;
   endtask

   initial begin
      exp_pc = RST_PC;
      exp_ir = '0;
      @(negedge clk);
      reset_state_checks();
      step();
      rst_n = 1'b1;
      for (int f = 0; f < 40; f++) begin
         run_fetch(f % 3 == 1, f % 4 == 2);
      end
      // reset inside a round
      alt_order = 1'b0;
      step();
      step();
      rst_n = 1'b0;
      @(negedge clk);
      reset_state_checks();
      rst_n = 1'b1;
      exp_pc = RST_PC;
      for (int f = 0; f < 6; f++) begin
         run_fetch(f[0], f == 3);
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule